// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous RAM with two independent access ports, left and right, that share one clock. Each port has two chip enables, a write strobe, two byte-lane enables, an address, write data, an output enable and an active-low interrupt output. A word is 18 bits wide, split into two 9-bit lanes, and each lane is written or read only when its lane enable is set. Read data appears one clock after the read access and is held until that port makes its next read.

The two highest addresses also serve as message slots between the ports. The top address belongs to the left port and the one below it belongs to the right port. When one port writes the other port's slot, the owner's interrupt goes low. It returns high when the owner reads its own slot. An asynchronous master reset raises both interrupts and clears the read registers. It leaves the stored words untouched.

Top module: `dpram_mbox`

## Requirements
- R1: A port makes an access on a clock edge only when its `ce0_n` is low and its `ce1` is high. Otherwise the edge writes nothing and leaves that port's read data unchanged.
- R2: An access with `we_n` low writes the lanes whose enable is set. `lanes[0]` covers word bits 8:0 and `lanes[1]` covers bits 17:9. Lanes that are not enabled keep their stored value.
- R3: An access with `we_n` high reads the addressed word. The result is presented from the edge of the access onward. Lanes that are not enabled read as zero.
- R4: `dout` carries the held read data and `dq_drive` is high only while `oe_n` is low. With `oe_n` high, `dout` is zero and `dq_drive` is low, with no clock needed.
- R5: The left mailbox is address 2^ADDR_W-1 and the right mailbox is address 2^ADDR_W-2. When one port writes the other port's mailbox with at least one lane enabled, the owner's `int_n` is low from that edge onward.
- R6: A port that reads its own mailbox drives its `int_n` high from that edge. If the other port writes that mailbox on the same edge, `int_n` stays low.
- R7: A port writing its own mailbox, or reading the other port's mailbox, leaves both interrupts unchanged.
- R8: Both mailbox addresses are also ordinary storage. A message written by one port reads back with the same data at the other port.
- R9: While `master_rst` is high, both `int_n` outputs are high and both read registers hold zero. This takes effect without a clock edge. Stored words survive a reset.
- R10: If both ports write the same address on one edge, each lane that the left port writes takes the left data. Lanes that only the right port writes take the right data.
- R11: A read of an address that the other port writes on the same edge returns the contents from before the write.
- R12: A write access with both lane enables clear changes no storage and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| master_rst | input | 1 | Asynchronous active-high master reset |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_we_n | input | 1 | Left write strobe: low writes, high reads |
| l_lanes | input | 2 | Left byte-lane enables |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 18 | Left write data |
| l_oe_n | input | 1 | Left output enable, active low |
| l_dout | output | 18 | Left read data, gated by output enable |
| l_dq_drive | output | 1 | Left data bus drive indication |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_we_n | input | 1 | Right write strobe: low writes, high reads |
| r_lanes | input | 2 | Right byte-lane enables |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 18 | Right write data |
| r_oe_n | input | 1 | Right output enable, active low |
| r_dout | output | 18 | Right read data, gated by output enable |
| r_dq_drive | output | 1 | Right data bus drive indication |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The bench targets the edges where the two ports meet.

- **Collisions.** Both ports write one address with overlapping lanes. A design that resolved the collision for the whole word, or in favour of the right port, would return the wrong upper or lower lane.
- **Read-before-write.** One port reads a word that the other port writes on the same edge. A design with write-first forwarding would return the new data.
- **Mailbox set and clear.** The bench checks a set and a clear landing on the same edge, reads of the other port's slot, writes to a port's own slot, and writes with no lane enabled. Each of these would leave an interrupt wrong if the address or lane decode were off by one.
- **Reset.** Master reset is raised between clock edges to expose a clocked rather than asynchronous reset. Stored data is then read back to catch a reset that wipes the array.

// File: rtl/dpram_mbox_pkg.sv
package dpram_mbox_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [LANES-1:0]  lanes_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e    op;
        lanes_t lanes;
    } acc_t;

    // Both enables must be active; the write strobe then picks the direction.
    function automatic op_e decode_op(logic ce0_n, logic ce1, logic we_n);
        if (ce0_n || !ce1) return OP_IDLE;
        return we_n ? OP_READ : OP_WRITE;
    endfunction

    // Distance of a port's mailbox below the top address.
    function automatic int unsigned mbox_offset(bit is_left);
        return is_left ? 0 : 1;
    endfunction

endpackage

// File: rtl/dpram_mbox_port.sv
module dpram_mbox_port
    import dpram_mbox_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter bit IS_LEFT = 1'b1
) (
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              we_n,
    input  lanes_t            lanes,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  word_t             rd_word,
    output acc_t              acc,
    output logic              own_mbox_rd,
    output logic              peer_mbox_wr,
    output word_t             dout,
    output logic              dq_drive
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
    localparam logic [ADDR_W-1:0] OWN_MB   = TOP_ADDR - ADDR_W'(mbox_offset(IS_LEFT));
    localparam logic [ADDR_W-1:0] PEER_MB  = TOP_ADDR - ADDR_W'(mbox_offset(!IS_LEFT));

    always_comb begin
        acc.op       = decode_op(ce0_n, ce1, we_n);
        acc.lanes    = lanes;
        own_mbox_rd  = (acc.op == OP_READ) && (addr == OWN_MB);
        peer_mbox_wr = (acc.op == OP_WRITE) && (|lanes) && (addr == PEER_MB);
    end

    // Output enable gates the held read data without any clocking.
    assign dq_drive = !oe_n;
    assign dout     = oe_n ? '0 : rd_word;

endmodule

// File: rtl/dpram_mbox_array.sv
module dpram_mbox_array
    import dpram_mbox_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              l_acc,
    input  logic [ADDR_W-1:0] l_addr,
    input  word_t             l_wdata,
    input  acc_t              r_acc,
    input  logic [ADDR_W-1:0] r_addr,
    input  word_t             r_wdata,
    output word_t             l_rword,
    output word_t             r_rword
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] l_q, r_q;
        logic              l_wr, r_wr;

        assign l_wr = (l_acc.op == OP_WRITE) && l_acc.lanes[g];
        assign r_wr = (r_acc.op == OP_WRITE) && r_acc.lanes[g];

        // Left update is scheduled last so it wins a same-address collision.
        always_ff @(posedge clk) begin
            if (r_wr) mem[r_addr] <= r_wdata[g*LANE_W +: LANE_W];
            if (l_wr) mem[l_addr] <= l_wdata[g*LANE_W +: LANE_W];
        end

        // Reads see the array before this edge's writes.
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                l_q <= '0;
                r_q <= '0;
            end else begin
                if (l_acc.op == OP_READ) l_q <= l_acc.lanes[g] ? mem[l_addr] : '0;
                if (r_acc.op == OP_READ) r_q <= r_acc.lanes[g] ? mem[r_addr] : '0;
            end
        end

        assign l_rword[g*LANE_W +: LANE_W] = l_q;
        assign r_rword[g*LANE_W +: LANE_W] = r_q;
    end

endmodule

// File: rtl/dpram_mbox_flags.sv
module dpram_mbox_flags #(
    parameter int SIDES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SIDES-1:0] set_req,
    input  logic [SIDES-1:0] clr_req,
    output logic [SIDES-1:0] int_n
);

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        logic pending;

        // A new message outranks an acknowledge on the same edge.
        always_ff @(posedge clk or posedge rst) begin
            if (rst)             pending <= 1'b0;
            else if (set_req[s]) pending <= 1'b1;
            else if (clr_req[s]) pending <= 1'b0;
        end

        assign int_n[s] = !pending;
    end

endmodule

// File: rtl/dpram_mbox.sv
module dpram_mbox
    import dpram_mbox_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              master_rst,
    input  logic              l_ce0_n,
    input  logic              l_ce1,
    input  logic              l_we_n,
    input  logic [1:0]        l_lanes,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [17:0]       l_wdata,
    input  logic              l_oe_n,
    output logic [17:0]       l_dout,
    output logic              l_dq_drive,
    output logic              l_int_n,
    input  logic              r_ce0_n,
    input  logic              r_ce1,
    input  logic              r_we_n,
    input  logic [1:0]        r_lanes,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [17:0]       r_wdata,
    input  logic              r_oe_n,
    output logic [17:0]       r_dout,
    output logic              r_dq_drive,
    output logic              r_int_n
);

    acc_t  l_acc, r_acc;
    word_t l_rword, r_rword;
    logic  l_own_rd, l_peer_wr, r_own_rd, r_peer_wr;
    logic [1:0] int_n_vec;

    dpram_mbox_port #(.ADDR_W(ADDR_W), .IS_LEFT(1'b1)) u_lport (
        .ce0_n(l_ce0_n), .ce1(l_ce1), .we_n(l_we_n), .lanes(l_lanes),
        .addr(l_addr), .oe_n(l_oe_n), .rd_word(l_rword), .acc(l_acc),
        .own_mbox_rd(l_own_rd), .peer_mbox_wr(l_peer_wr),
        .dout(l_dout), .dq_drive(l_dq_drive)
    );

    dpram_mbox_port #(.ADDR_W(ADDR_W), .IS_LEFT(1'b0)) u_rport (
        .ce0_n(r_ce0_n), .ce1(r_ce1), .we_n(r_we_n), .lanes(r_lanes),
        .addr(r_addr), .oe_n(r_oe_n), .rd_word(r_rword), .acc(r_acc),
        .own_mbox_rd(r_own_rd), .peer_mbox_wr(r_peer_wr),
        .dout(r_dout), .dq_drive(r_dq_drive)
    );

    dpram_mbox_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(master_rst),
        .l_acc(l_acc), .l_addr(l_addr), .l_wdata(l_wdata),
        .r_acc(r_acc), .r_addr(r_addr), .r_wdata(r_wdata),
        .l_rword(l_rword), .r_rword(r_rword)
    );

    // Index 0 is the left port, index 1 the right port.
    dpram_mbox_flags #(.SIDES(2)) u_flags (
        .clk(clk), .rst(master_rst),
        .set_req({l_peer_wr, r_peer_wr}),
        .clr_req({r_own_rd, l_own_rd}),
        .int_n(int_n_vec)
    );

    assign l_int_n = int_n_vec[0];
    assign r_int_n = int_n_vec[1];

endmodule

// File: rtl/dpram_mbox_chk.sv
module dpram_mbox_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              master_rst,
    input logic              l_ce0_n,
    input logic              l_ce1,
    input logic              l_we_n,
    input logic [1:0]        l_lanes,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_oe_n,
    input logic [17:0]       l_dout,
    input logic              l_dq_drive,
    input logic              l_int_n,
    input logic              r_ce0_n,
    input logic              r_ce1,
    input logic              r_we_n,
    input logic [1:0]        r_lanes,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_oe_n,
    input logic [17:0]       r_dout,
    input logic              r_dq_drive,
    input logic              r_int_n
);

    localparam logic [ADDR_W-1:0] L_MB = '1;
    localparam logic [ADDR_W-1:0] R_MB = L_MB - 1'b1;

    logic l_on, r_on, l_set, r_set, l_clr, r_clr;
    assign l_on  = !l_ce0_n && l_ce1;
    assign r_on  = !r_ce0_n && r_ce1;
    assign l_set = r_on && !r_we_n && (|r_lanes) && (r_addr == L_MB);
    assign r_set = l_on && !l_we_n && (|l_lanes) && (l_addr == R_MB);
    assign l_clr = l_on && l_we_n && (l_addr == L_MB);
    assign r_clr = r_on && r_we_n && (r_addr == R_MB);

    // R9: reset leaves both interrupts inactive
    a_r9_rst_flags: assert property (@(posedge clk)
        master_rst |=> (l_int_n && r_int_n));

    // R4: disabled output enable keeps both buses quiet
    a_r4_l_oe: assert property (@(posedge clk)
        l_oe_n |-> (!l_dq_drive && l_dout == '0));
    a_r4_r_oe: assert property (@(posedge clk)
        r_oe_n |-> (!r_dq_drive && r_dout == '0));

    // R5: message write to the other port's slot raises its interrupt
    a_r5_l_set: assert property (@(posedge clk) disable iff (master_rst)
        l_set |=> !l_int_n);
    a_r5_r_set: assert property (@(posedge clk) disable iff (master_rst)
        r_set |=> !r_int_n);

    // R6: owner read clears unless a new message lands on the same edge
    a_r6_l_clr: assert property (@(posedge clk) disable iff (master_rst)
        (l_clr && !l_set) |=> l_int_n);
    a_r6_r_clr: assert property (@(posedge clk) disable iff (master_rst)
        (r_clr && !r_set) |=> r_int_n);

    // R7: no set and no clear means the interrupt holds
    a_r7_l_hold: assert property (@(posedge clk) disable iff (master_rst)
        (!l_set && !l_clr) |=> $stable(l_int_n));
    a_r7_r_hold: assert property (@(posedge clk) disable iff (master_rst)
        (!r_set && !r_clr) |=> $stable(r_int_n));

endmodule

bind dpram_mbox dpram_mbox_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .master_rst(master_rst),
    .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_we_n(l_we_n), .l_lanes(l_lanes),
    .l_addr(l_addr), .l_oe_n(l_oe_n), .l_dout(l_dout),
    .l_dq_drive(l_dq_drive), .l_int_n(l_int_n),
    .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_we_n(r_we_n), .r_lanes(r_lanes),
    .r_addr(r_addr), .r_oe_n(r_oe_n), .r_dout(r_dout),
    .r_dq_drive(r_dq_drive), .r_int_n(r_int_n)
);

// File: tb/dpram_mbox_test.sv
`timescale 1ns/1ps
module dpram_mbox_test;

    localparam int AW = 8;
    localparam logic [AW-1:0] L_MB = '1;
    localparam logic [AW-1:0] R_MB = L_MB - 1'b1;
    localparam bit LEFT = 1'b0;
    localparam bit RIGHT = 1'b1;

    logic clk = 1'b0;
    logic master_rst = 1'b1;
    logic l_ce0_n = 1'b1, l_ce1 = 1'b0, l_we_n = 1'b1, l_oe_n = 1'b0;
    logic r_ce0_n = 1'b1, r_ce1 = 1'b0, r_we_n = 1'b1, r_oe_n = 1'b0;
    logic [1:0] l_lanes = '0, r_lanes = '0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [17:0] l_wdata = '0, r_wdata = '0;
    logic [17:0] l_dout, r_dout;
    logic l_dq_drive, r_dq_drive, l_int_n, r_int_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dpram_mbox #(.ADDR_W(AW)) uut (
        .clk(clk), .master_rst(master_rst),
        .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_we_n(l_we_n), .l_lanes(l_lanes),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_oe_n(l_oe_n),
        .l_dout(l_dout), .l_dq_drive(l_dq_drive), .l_int_n(l_int_n),
        .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_we_n(r_we_n), .r_lanes(r_lanes),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_oe_n(r_oe_n),
        .r_dout(r_dout), .r_dq_drive(r_dq_drive), .r_int_n(r_int_n)
    );

    task automatic check(input logic [17:0] act, input logic [17:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_ce0_n = 1'b1; l_ce1 = 1'b0; l_we_n = 1'b1; l_lanes = '0;
        r_ce0_n = 1'b1; r_ce1 = 1'b0; r_we_n = 1'b1; r_lanes = '0;
    endtask

    task automatic drv(input bit side, input logic c0, input logic c1, input logic wn,
                       input logic [1:0] ln, input logic [AW-1:0] a, input logic [17:0] d);
        if (side == RIGHT) begin
            r_ce0_n = c0; r_ce1 = c1; r_we_n = wn; r_lanes = ln; r_addr = a; r_wdata = d;
        end else begin
            l_ce0_n = c0; l_ce1 = c1; l_we_n = wn; l_lanes = ln; l_addr = a; l_wdata = d;
        end
    endtask

    task automatic wr(input bit side, input logic [1:0] ln, input logic [AW-1:0] a, input logic [17:0] d);
        drv(side, 1'b0, 1'b1, 1'b0, ln, a, d);
    endtask

    task automatic rd(input bit side, input logic [1:0] ln, input logic [AW-1:0] a);
        drv(side, 1'b0, 1'b1, 1'b1, ln, a, '0);
    endtask

    // Inputs change at falling edges; results are read at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        check({17'd0, l_int_n}, 18'd1, "R9 left int_n in reset");
        check({17'd0, r_int_n}, 18'd1, "R9 right int_n in reset");
        check(l_dout, '0, "R9 left read register in reset");
        @(negedge clk); master_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rw();
        logic [17:0] v = 18'h2A5C3;
        wr(LEFT, 2'b11, 8'd5, v); step();
        rd(LEFT, 2'b11, 8'd5); step();
        check(l_dout, v, "R3 left full read");
        rd(RIGHT, 2'b11, 8'd5); step();
        check(r_dout, v, "R3 right full read");
        wr(RIGHT, 2'b01, 8'd5, 18'h3FFFF); step();
        v = {v[17:9], 9'h1FF};
        rd(LEFT, 2'b11, 8'd5); step();
        check(l_dout, v, "R2 lane0-only write keeps lane1");
        wr(LEFT, 2'b10, 8'd5, 18'h00000); step();
        v = {9'h000, v[8:0]};
        rd(LEFT, 2'b11, 8'd5); step();
        check(l_dout, v, "R2 lane1-only write keeps lane0");
        rd(RIGHT, 2'b01, 8'd5); step();
        check(r_dout, {9'h000, v[8:0]}, "R3 unselected lane1 reads zero");
        wr(LEFT, 2'b11, 8'd6, 18'h12345); step();
        rd(LEFT, 2'b10, 8'd6); step();
        check(l_dout, 18'h12345 & 18'h3FE00, "R3 unselected lane0 reads zero");
    endtask

    task automatic t_enables();
        wr(LEFT, 2'b11, 8'd7, 18'h11111); step();
        drv(LEFT, 1'b1, 1'b1, 1'b0, 2'b11, 8'd7, 18'h22222); step();
        drv(LEFT, 1'b0, 1'b0, 1'b0, 2'b11, 8'd7, 18'h33333); step();
        rd(LEFT, 2'b11, 8'd7); step();
        check(l_dout, 18'h11111, "R1 disabled writes ignored");
        drv(LEFT, 1'b1, 1'b1, 1'b1, 2'b11, 8'd6, '0); step();
        check(l_dout, 18'h11111, "R1 read with ce0_n high keeps read data");
        drv(LEFT, 1'b0, 1'b0, 1'b1, 2'b11, 8'd6, '0); step();
        check(l_dout, 18'h11111, "R1 read with ce1 low keeps read data");
        l_oe_n = 1'b1; #1;
        check(l_dout, '0, "R4 dout zero with oe_n high");
        check({17'd0, l_dq_drive}, 18'd0, "R4 dq_drive low with oe_n high");
        l_oe_n = 1'b0; #1;
        check(l_dout, 18'h11111, "R4 held data returns with oe_n low");
        check({17'd0, l_dq_drive}, 18'd1, "R4 dq_drive high with oe_n low");
    endtask

    task automatic t_mailbox();
        wr(RIGHT, 2'b00, L_MB, 18'h0AAAA); step();
        check({17'd0, l_int_n}, 18'd1, "R12 no-lane write raises nothing");
        wr(LEFT, 2'b11, L_MB, 18'h01234); step();
        check({17'd0, l_int_n}, 18'd1, "R7 own-mailbox write keeps left int_n");
        check({17'd0, r_int_n}, 18'd1, "R7 own-mailbox write keeps right int_n");
        wr(RIGHT, 2'b11, L_MB, 18'h2BEEF); step();
        check({17'd0, l_int_n}, 18'd0, "R5 right writes left mailbox");
        check({17'd0, r_int_n}, 18'd1, "R5 right int_n unaffected");
        rd(LEFT, 2'b11, R_MB); step();
        check({17'd0, l_int_n}, 18'd0, "R7 reading peer mailbox keeps int_n");
        wr(RIGHT, 2'b01, L_MB, 18'h00077); rd(LEFT, 2'b11, L_MB); step();
        check({17'd0, l_int_n}, 18'd0, "R6 set wins over clear on same edge");
        check(l_dout, 18'h2BEEF, "R11 mailbox read before same-edge write");
        rd(LEFT, 2'b11, L_MB); step();
        check({17'd0, l_int_n}, 18'd1, "R6 owner read clears left int_n");
        check(l_dout, {9'h15F, 9'h077}, "R8 left mailbox holds right's message");
        wr(LEFT, 2'b10, R_MB, 18'h3FE00); step();
        check({17'd0, r_int_n}, 18'd0, "R5 left writes right mailbox");
        rd(RIGHT, 2'b11, R_MB); step();
        check({17'd0, r_int_n}, 18'd1, "R6 owner read clears right int_n");
        check(r_dout & 18'h3FE00, 18'h3FE00, "R8 right mailbox holds left's lane1");
    endtask

    task automatic t_collide();
        wr(LEFT, 2'b11, 8'd10, 18'h00000); step();
        wr(LEFT, 2'b01, 8'd10, 18'h15555); wr(RIGHT, 2'b11, 8'd10, 18'h2AAAA); step();
        rd(RIGHT, 2'b11, 8'd10); step();
        check(r_dout, {18'h2AAAA >> 9, 9'(18'h15555)}, "R10 per-lane left wins");
        wr(LEFT, 2'b11, 8'd20, 18'h0C0DE); step();
        wr(LEFT, 2'b11, 8'd20, 18'h3F00F); rd(RIGHT, 2'b11, 8'd20); step();
        check(r_dout, 18'h0C0DE, "R11 right read sees old word");
        rd(RIGHT, 2'b11, 8'd20); step();
        check(r_dout, 18'h3F00F, "R11 new word visible afterwards");
    endtask

    task automatic t_async_reset();
        wr(RIGHT, 2'b11, L_MB, 18'h00001); step();
        rd(LEFT, 2'b11, 8'd20); step();
        check({17'd0, l_int_n}, 18'd0, "R5 interrupt pending before reset");
        #1 master_rst = 1'b1;
        #1;
        check({17'd0, l_int_n}, 18'd1, "R9 async reset raises int_n");
        check(l_dout, '0, "R9 async reset clears read register");
        @(negedge clk); master_rst = 1'b0;
        rd(LEFT, 2'b11, 8'd20); step();
        check(l_dout, 18'h3F00F, "R9 storage survives reset");
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual still running, expected finished");
        report();
    end

    initial begin
        idle();
        repeat (2) @(negedge clk);
        t_reset();
        t_rw();
        t_enables();
        t_mailbox();
        t_collide();
        t_async_reset();
        report();
    end

endmodule